// File: doc/BRIEF.md
# Operand Bypass and Pipeline Hazard Controller

This block resolves hazards in a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. It is purely combinational. Its inputs are the register specifiers and control bits held in the pipeline registers. For each of the two execute-stage ALU operands it produces a 2-bit bypass select. It also drives the hold, flush and bubble controls that the pipeline registers and the program counter obey.

A bypass select picks the newest copy of a source register. That copy may be the previous ALU result waiting in the execute/memory register. It may be the value in the memory/writeback register. Otherwise the operand comes from the register file. The register file writes in the first half of a cycle and reads in the second half, so a decode-stage read already sees a same-cycle writeback and needs no bypass.

A load followed at once by a consumer of its result cannot be covered by bypassing. In that case the block freezes the program counter and the fetch/decode register for one cycle and injects an empty slot into the decode/execute register. Branches are assumed not taken. When one resolves taken, the two younger instructions are squashed. A squash overrides a pending load-use stall.

Top module: `hzd_unit`

## Requirements
- R1: `fwd_a` is 2'b10 when `exmem_wen` is 1, `exmem_rd` is not 0 and `exmem_rd` equals `idex_rs`; `fwd_b` is 2'b10 under the same test against `idex_rt`.
- R2: `fwd_a`/`fwd_b` is 2'b01 when `memwb_wen` is 1, `memwb_rd` is not 0, `memwb_rd` equals the operand's source, and R1 does not apply to that operand.
- R3: When both the execute/memory and the memory/writeback destinations match an operand's source, the select is 2'b10.
- R4: Register 0 is never bypassed: a source of 0 gives select 2'b00 even if a writing stage names register 0 as its destination.
- R5: With no enabled matching writer, or with the matching writers' write-enables low, the select is 2'b00 (register file).
- R6: When `idex_mem_read` is 1 and `idex_rd` equals `ifid_rs` or `ifid_rt`, and `branch_taken` is 0, a stall is raised: `pc_hold`, `ifid_hold` and `idex_bubble` are 1 and `ifid_flush` is 0.
- R7: `pc_hold` and `ifid_hold` are always equal.
- R8: No stall is raised when the execute-stage instruction is not a load, or when only the execute/memory or memory/writeback destinations match the decode-stage sources. In this state all four control outputs are 0 when `branch_taken` is 0.
- R9: When `branch_taken` is 1, `ifid_flush` and `idex_bubble` are 1 and `pc_hold` and `ifid_hold` are 0.
- R10: When a load-use stall and `branch_taken` coincide, the flush outcome of R9 applies and no hold is asserted.
- R11: The two operand selects are computed independently. Operand A and operand B can carry different codes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs | input | REG_ADDR_W | First source specifier of the execute-stage instruction |
| idex_rt | input | REG_ADDR_W | Second source specifier of the execute-stage instruction |
| idex_rd | input | REG_ADDR_W | Load destination held in the decode/execute register |
| idex_mem_read | input | 1 | Execute-stage instruction is a load |
| exmem_rd | input | REG_ADDR_W | Destination held in the execute/memory register |
| exmem_wen | input | 1 | Execute/memory instruction writes a register |
| memwb_rd | input | REG_ADDR_W | Destination held in the memory/writeback register |
| memwb_wen | input | 1 | Memory/writeback instruction writes a register |
| ifid_rs | input | REG_ADDR_W | First source specifier of the decode-stage instruction |
| ifid_rt | input | REG_ADDR_W | Second source specifier of the decode-stage instruction |
| branch_taken | input | 1 | A branch has resolved taken this cycle |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 writeback, 10 prior ALU |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Clear the fetch/decode register to a no-op |
| idex_bubble | output | 1 | Load zeroed control into the decode/execute register |

## Verification
The bench targets the priority case where both later stages write the operand's source. A design that let the writeback path win would feed a stale value, and the bench sees 01 where 10 is due. It sets destination register 0 with its write-enable high. A missing zero guard would then show a bypass code where 00 is expected. It also pairs a load-use match with a taken branch. A design that let the stall win would show a held program counter instead of a flush. Other cases cover a non-load producer matching decode sources, which must not stall, and operands given different sources, to catch selects wired to the wrong source.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;

   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WB  = 2'b01,
      FWD_MEM = 2'b10
   } fwd_sel_e;

   localparam int NUM_OPERANDS = 2;

   typedef struct packed {
      logic pc_hold;
      logic ifid_hold;
      logic ifid_flush;
      logic idex_bubble;
   } pipe_ctl_t;

endpackage

// File: rtl/hzd_fwd_sel.sv
`timescale 1ns/1ps
module hzd_fwd_sel #(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_GUARD = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] src,
   input  logic [REG_ADDR_W-1:0] exmem_rd,
   input  logic                  exmem_wen,
   input  logic [REG_ADDR_W-1:0] memwb_rd,
   input  logic                  memwb_wen,
   output logic [1:0]            sel
);
   import hzd_pkg::*;

   localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

   logic exmem_live;
   logic memwb_live;
   logic exmem_hit;
   logic memwb_hit;

   // Writer qualification: with the guard, register 0 never counts as a live producer.
   generate
      if (ZERO_REG_GUARD) begin : g_guard
         assign exmem_live = exmem_wen && (exmem_rd != ZERO_REG);
         assign memwb_live = memwb_wen && (memwb_rd != ZERO_REG);
      end else begin : g_noguard
         assign exmem_live = exmem_wen;
         assign memwb_live = memwb_wen;
      end
   endgenerate

   assign exmem_hit = exmem_live && (exmem_rd == src);
   assign memwb_hit = memwb_live && (memwb_rd == src);

   // The younger producer (execute/memory) takes priority.
   always_comb begin
      fwd_sel_e s;
      if (exmem_hit)      s = FWD_MEM;
      else if (memwb_hit) s = FWD_WB;
      else                s = FWD_RF;
      sel = s;
   end

endmodule

// File: rtl/hzd_load_use.sv
`timescale 1ns/1ps
module hzd_load_use #(
   parameter int REG_ADDR_W = 5
) (
   input  logic                  idex_mem_read,
   input  logic [REG_ADDR_W-1:0] idex_rd,
   input  logic [REG_ADDR_W-1:0] ifid_rs,
   input  logic [REG_ADDR_W-1:0] ifid_rt,
   output logic                  stall_req
);
   logic [1:0] src_hit;

   assign src_hit[0] = (idex_rd == ifid_rs);
   assign src_hit[1] = (idex_rd == ifid_rt);
   assign stall_req  = idex_mem_read && (|src_hit);

endmodule

// File: rtl/hzd_branch_ctl.sv
`timescale 1ns/1ps
module hzd_branch_ctl (
   input  logic               stall_req,
   input  logic               branch_taken,
   output hzd_pkg::pipe_ctl_t ctl
);
   always_comb begin
      ctl = '0;
      if (branch_taken) begin
         // squash wins over a stall: younger slots are discarded anyway
         ctl.ifid_flush  = 1'b1;
         ctl.idex_bubble = 1'b1;
      end else if (stall_req) begin
         ctl.pc_hold     = 1'b1;
         ctl.ifid_hold   = 1'b1;
         ctl.idex_bubble = 1'b1;
      end
   end
endmodule

// File: rtl/hzd_unit.sv
`timescale 1ns/1ps
module hzd_unit #(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_GUARD = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] idex_rs,
   input  logic [REG_ADDR_W-1:0] idex_rt,
   input  logic [REG_ADDR_W-1:0] idex_rd,
   input  logic                  idex_mem_read,
   input  logic [REG_ADDR_W-1:0] exmem_rd,
   input  logic                  exmem_wen,
   input  logic [REG_ADDR_W-1:0] memwb_rd,
   input  logic                  memwb_wen,
   input  logic [REG_ADDR_W-1:0] ifid_rs,
   input  logic [REG_ADDR_W-1:0] ifid_rt,
   input  logic                  branch_taken,
   output logic [1:0]            fwd_a,
   output logic [1:0]            fwd_b,
   output logic                  pc_hold,
   output logic                  ifid_hold,
   output logic                  ifid_flush,
   output logic                  idex_bubble
);
   import hzd_pkg::*;

   generate
      if (REG_ADDR_W < 1 || REG_ADDR_W > 8) begin : g_bad_width
         $error("hzd_unit: REG_ADDR_W must be 1..8");
      end
   endgenerate

   logic [REG_ADDR_W-1:0] op_src [NUM_OPERANDS];
   logic [1:0]            op_sel [NUM_OPERANDS];
   logic                  stall_req;
   pipe_ctl_t             ctl;

   assign op_src[0] = idex_rs;
   assign op_src[1] = idex_rt;

   generate
      for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_op
         hzd_fwd_sel #(
            .REG_ADDR_W    (REG_ADDR_W),
            .ZERO_REG_GUARD(ZERO_REG_GUARD)
         ) sel_i (
            .src      (op_src[g]),
            .exmem_rd (exmem_rd),
            .exmem_wen(exmem_wen),
            .memwb_rd (memwb_rd),
            .memwb_wen(memwb_wen),
            .sel      (op_sel[g])
         );
      end
   endgenerate

   hzd_load_use #(.REG_ADDR_W(REG_ADDR_W)) lu_i (
      .idex_mem_read(idex_mem_read),
      .idex_rd      (idex_rd),
      .ifid_rs      (ifid_rs),
      .ifid_rt      (ifid_rt),
      .stall_req    (stall_req)
   );

   hzd_branch_ctl br_i (
      .stall_req   (stall_req),
      .branch_taken(branch_taken),
      .ctl         (ctl)
   );

   assign fwd_a       = op_sel[0];
   assign fwd_b       = op_sel[1];
   assign pc_hold     = ctl.pc_hold;
   assign ifid_hold   = ctl.ifid_hold;
   assign ifid_flush  = ctl.ifid_flush;
   assign idex_bubble = ctl.idex_bubble;

endmodule

// File: rtl/hzd_unit_chk.sv
`timescale 1ns/1ps
module hzd_unit_chk #(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_GUARD = 1'b1
) (
   input logic [REG_ADDR_W-1:0] idex_rs,
   input logic [REG_ADDR_W-1:0] idex_rt,
   input logic [REG_ADDR_W-1:0] idex_rd,
   input logic                  idex_mem_read,
   input logic [REG_ADDR_W-1:0] exmem_rd,
   input logic                  exmem_wen,
   input logic [REG_ADDR_W-1:0] memwb_rd,
   input logic                  memwb_wen,
   input logic [REG_ADDR_W-1:0] ifid_rs,
   input logic [REG_ADDR_W-1:0] ifid_rt,
   input logic                  branch_taken,
   input logic [1:0]            fwd_a,
   input logic [1:0]            fwd_b,
   input logic                  pc_hold,
   input logic                  ifid_hold,
   input logic                  ifid_flush,
   input logic                  idex_bubble
);
   logic known;
   assign known = !$isunknown({idex_rs, idex_rt, idex_rd, idex_mem_read, exmem_rd,
                               exmem_wen, memwb_rd, memwb_wen, ifid_rs, ifid_rt,
                               branch_taken, fwd_a, fwd_b, pc_hold, ifid_hold,
                               ifid_flush, idex_bubble});

   always_comb begin
      if (known) begin
         p_mem_src_a_r1: assert (fwd_a != 2'b10 || (exmem_wen && exmem_rd == idex_rs))
            else $error("fwd_a=10 without a matching execute/memory writer");
         p_mem_src_b_r1: assert (fwd_b != 2'b10 || (exmem_wen && exmem_rd == idex_rt))
            else $error("fwd_b=10 without a matching execute/memory writer");
         // R2 and R3: writeback path chosen only when the younger stage does not match
         p_wb_src_a_r2: assert (fwd_a != 2'b01 ||
                                (memwb_wen && memwb_rd == idex_rs &&
                                 !(exmem_wen && exmem_rd == idex_rs && exmem_rd != '0)))
            else $error("fwd_a=01 with wrong writeback or younger match");
         p_no_code11_r11: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
            else $error("reserved bypass code");
         if (ZERO_REG_GUARD) begin
            p_zero_src_r4: assert ((idex_rs != '0 || fwd_a == 2'b00) &&
                                   (idex_rt != '0 || fwd_b == 2'b00))
               else $error("register 0 bypassed");
         end
         p_stall_r6: assert (!(idex_mem_read && !branch_taken &&
                               (idex_rd == ifid_rs || idex_rd == ifid_rt)) ||
                             (pc_hold && idex_bubble && !ifid_flush))
            else $error("load-use without stall");
         p_hold_pair_r7: assert (pc_hold == ifid_hold)
            else $error("pc and fetch/decode holds disagree");
         p_no_load_r8: assert (idex_mem_read || branch_taken || (!pc_hold && !idex_bubble))
            else $error("stall without a load in execute");
         p_flush_r10: assert (!branch_taken || (ifid_flush && idex_bubble && !pc_hold))
            else $error("taken branch did not squash");
      end
   end
endmodule

bind hzd_unit hzd_unit_chk #(
   .REG_ADDR_W    (REG_ADDR_W),
   .ZERO_REG_GUARD(ZERO_REG_GUARD)
) chk_i (
   .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_rd(idex_rd),
   .idex_mem_read(idex_mem_read), .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
   .memwb_rd(memwb_rd), .memwb_wen(memwb_wen), .ifid_rs(ifid_rs),
   .ifid_rt(ifid_rt), .branch_taken(branch_taken), .fwd_a(fwd_a),
   .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
   .ifid_flush(ifid_flush), .idex_bubble(idex_bubble)
);

// File: tb/hzd_unit_tb_top.sv
`timescale 1ns/1ps
module hzd_unit_tb_top;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [AW-1:0] idex_rs, idex_rt, idex_rd, exmem_rd, memwb_rd, ifid_rs, ifid_rt;
   logic idex_mem_read, exmem_wen, memwb_wen, branch_taken;
   logic [1:0] fwd_a, fwd_b;
   logic pc_hold, ifid_hold, ifid_flush, idex_bubble;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   hzd_unit #(.REG_ADDR_W(AW)) dut_i (
      .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_rd(idex_rd),
      .idex_mem_read(idex_mem_read), .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
      .memwb_rd(memwb_rd), .memwb_wen(memwb_wen), .ifid_rs(ifid_rs),
      .ifid_rt(ifid_rt), .branch_taken(branch_taken), .fwd_a(fwd_a),
      .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
      .ifid_flush(ifid_flush), .idex_bubble(idex_bubble)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle();
      idex_rs = '0; idex_rt = '0; idex_rd = '0; idex_mem_read = 1'b0;
      exmem_rd = '0; exmem_wen = 1'b0; memwb_rd = '0; memwb_wen = 1'b0;
      ifid_rs = '0; ifid_rt = '0; branch_taken = 1'b0;
   endtask

   // apply on the falling edge, sample one ns later
   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic check_ctl(input string req, input int ph, input int fl, input int bub);
      check(req, "pc_hold", pc_hold, ph);
      check(req, "ifid_hold", ifid_hold, ph);
      check(req, "ifid_flush", ifid_flush, fl);
      check(req, "idex_bubble", idex_bubble, bub);
   endtask

   task automatic t_reset();
      idle(); settle();
      check("R5", "fwd_a idle", fwd_a, 0);
      check("R5", "fwd_b idle", fwd_b, 0);
      check_ctl("R8", 0, 0, 0);
   endtask

   task automatic t_exmem();
      idle(); idex_rs = 5'd3; idex_rt = 5'd7; exmem_rd = 5'd3; exmem_wen = 1'b1; settle();
      check("R1", "fwd_a exmem", fwd_a, 2);
      check("R1", "fwd_b other", fwd_b, 0);
      idex_rs = 5'd9; idex_rt = 5'd3; settle();
      check("R1", "fwd_b exmem", fwd_b, 2);
      check("R1", "fwd_a other", fwd_a, 0);
   endtask

   task automatic t_memwb();
      idle(); idex_rs = 5'd12; idex_rt = 5'd12; memwb_rd = 5'd12; memwb_wen = 1'b1;
      exmem_rd = 5'd4; exmem_wen = 1'b1; settle();
      check("R2", "fwd_a wb", fwd_a, 1);
      check("R2", "fwd_b wb", fwd_b, 1);
   endtask

   task automatic t_priority();
      idle(); idex_rs = 5'd21; idex_rt = 5'd21; exmem_rd = 5'd21; exmem_wen = 1'b1;
      memwb_rd = 5'd21; memwb_wen = 1'b1; settle();
      check("R3", "fwd_a both", fwd_a, 2);
      check("R3", "fwd_b both", fwd_b, 2);
      // younger stage matches but does not write: older one is used
      exmem_wen = 1'b0; settle();
      check("R3", "fwd_a exmem disabled", fwd_a, 1);
   endtask

   task automatic t_zero();
      idle(); exmem_rd = '0; exmem_wen = 1'b1; memwb_rd = '0; memwb_wen = 1'b1; settle();
      check("R4", "fwd_a reg0", fwd_a, 0);
      check("R4", "fwd_b reg0", fwd_b, 0);
      // zero at exmem must not hide a real writeback match for a nonzero source
      idex_rs = 5'd6; memwb_rd = 5'd6; settle();
      check("R4", "fwd_a wb under zero exmem", fwd_a, 1);
   endtask

   task automatic t_none();
      idle(); idex_rs = 5'd5; idex_rt = 5'd8; exmem_rd = 5'd5; memwb_rd = 5'd8; settle();
      check("R5", "fwd_a wen low", fwd_a, 0);
      check("R5", "fwd_b wen low", fwd_b, 0);
      exmem_wen = 1'b1; memwb_wen = 1'b1; exmem_rd = 5'd30; memwb_rd = 5'd31; settle();
      check("R5", "fwd_a no match", fwd_a, 0);
      check("R5", "fwd_b no match", fwd_b, 0);
   endtask

   task automatic t_independent();
      idle(); idex_rs = 5'd10; idex_rt = 5'd11; exmem_rd = 5'd11; exmem_wen = 1'b1;
      memwb_rd = 5'd10; memwb_wen = 1'b1; settle();
      check("R11", "fwd_a wb", fwd_a, 1);
      check("R11", "fwd_b mem", fwd_b, 2);
   endtask

   task automatic t_load_use();
      idle(); idex_mem_read = 1'b1; idex_rd = 5'd14; ifid_rs = 5'd14; ifid_rt = 5'd2; settle();
      check_ctl("R6", 1, 0, 1);
      ifid_rs = 5'd2; ifid_rt = 5'd14; settle();
      check_ctl("R6", 1, 0, 1);
      check("R7", "hold pair", pc_hold == ifid_hold, 1);
   endtask

   task automatic t_no_stall();
      idle(); idex_rd = 5'd14; ifid_rs = 5'd14; settle();
      check_ctl("R8", 0, 0, 0);
      idex_mem_read = 1'b1; idex_rd = 5'd1; exmem_rd = 5'd14; exmem_wen = 1'b1;
      memwb_rd = 5'd15; memwb_wen = 1'b1; ifid_rt = 5'd15; settle();
      check_ctl("R8", 0, 0, 0);
   endtask

   task automatic t_branch();
      idle(); branch_taken = 1'b1; settle();
      check_ctl("R9", 0, 1, 1);
   endtask

   task automatic t_flush_vs_stall();
      idle(); idex_mem_read = 1'b1; idex_rd = 5'd9; ifid_rt = 5'd9; branch_taken = 1'b1; settle();
      check_ctl("R10", 0, 1, 1);
      branch_taken = 1'b0; settle();
      check_ctl("R10", 1, 0, 1);
   endtask

   initial begin
      idle();
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_exmem();
      t_memwb();
      t_priority();
      t_zero();
      t_none();
      t_independent();
      t_load_use();
      t_no_stall();
      t_branch();
      t_flush_vs_stall();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule